// File: doc/BRIEF.md
# Synchronous Burst Read Port with Programmable Initial Latency

This block is the device end of a synchronous burst read channel on a 16-bit bus that carries both address and data. The host drives a start address on the bus and pulls the address strobe low while chip-enable is low. The clock edge that samples the strobe captures the address. The block then counts a programmable number of clocks before it presents the first word. After that it presents one new word on every rising edge, stepping through an 8-word aligned group and wrapping inside it. A ready output goes high together with the first word, so the host can wait for ready and does not need to count clocks itself.

The initial latency lives in a configuration register next to a high-frequency mode bit. That bit is exported for the clocking logic around the block. Writes that carry an illegal setting are refused as a whole. The bus is modelled here as separate input, output and drive-enable signals, and the pad-level tri-state buffer sits outside the block. The drive enable is high only while a burst is being presented and both chip-enable and output-enable are low. The words come from an internal data source: each word is its own address XORed with the constant `16'h5A3C`.

Top module: `burst_rd_port`

## Requirements
- R1: While reset is applied and after it is released, `ready` and `ad_drv` are 0, `hf_mode` is 0 and the latency setting is 4.
- R2: A configuration write (`cfg_we`=1 at a rising edge) with `cfg_lat` in 3..7 is accepted. The new latency governs the following bursts, and `hf_mode` takes the value of `cfg_hf`.
- R3: A configuration write with `cfg_lat` of 0, 1 or 2 is refused. Both latency and `hf_mode` keep their previous values.
- R4: A configuration write with `cfg_lat`=3 and `cfg_hf`=1 is refused. Both fields keep their previous values.
- R5: Call the rising edge that samples `ce_n`=0 and `addr_stb_n`=0 edge E0, and let the latency be L. After edge E0+L, `ready` is 1 and `ad_out` holds the word for the start address, so the host samples it at edge E0+L+1.
- R6: From edge E0 until edge E0+L, `ready` stays 0 and `ad_drv` is 0.
- R7: After each later edge with `ce_n`=0 and `addr_stb_n`=1, the next word appears on `ad_out` and `ready` stays 1. The word for address A is `A ^ 16'h5A3C`.
- R8: The word address is `{start[15:3], idx}`. `idx` begins at `start[2:0]` and goes from 7 back to 0.
- R9: `ad_drv` is 0 whenever `ce_n` or `oe_n` is 1. Raising only `oe_n` during a burst does not pause the word sequence.
- R10: After an edge that samples `ce_n`=1, `ready` and `ad_drv` are 0 and the burst is over.
- R11: An address strobe during a burst aborts it. `ready` drops after that edge, and the latency count restarts from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_stb_n | input | 1 | Address-valid strobe, active low |
| ad_in | input | 16 | Bus value seen by the device (start address) |
| ad_out | output | 16 | Burst word to drive onto the bus |
| ad_drv | output | 1 | Pad drive enable; bus is high impedance when 0 |
| ready | output | 1 | High from the first valid word for the rest of the burst |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lat | input | 3 | Requested initial latency in clocks |
| cfg_hf | input | 1 | Requested high-frequency mode bit |
| hf_mode | output | 1 | Current high-frequency mode bit |

## Verification
The latch edge counts as edge zero. `ready` and the first word are due exactly L edges later, each following word one edge after that, and `ready` falls one edge after chip-enable is sampled high. `ad_drv` follows `oe_n` and `ce_n` in the same cycle. A configuration write takes effect one edge after it is sampled. Inputs change at the falling clock edge, and outputs are read at the falling edge that follows the rising edge being counted. Each scenario task walks the edges one at a time and checks `ready` low on every intermediate edge, so a latency off by one in either direction fails.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Sequencer phases of one burst access
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } seq_st_t;

endpackage

// File: rtl/burst_lat_cfg.sv
module burst_lat_cfg #(
  parameter int LAT_W    = 3,
  parameter int LAT_MIN  = 3,
  parameter int LAT_MAX  = 7,
  parameter int LAT_RST  = 4,
  parameter int LAT_NOHF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_lat,
  input  logic             wr_hf,
  output logic [LAT_W-1:0] lat_q,
  output logic             hf_q
);

  localparam logic [LAT_W-1:0] MIN_V  = LAT_W'(LAT_MIN);
  localparam logic [LAT_W-1:0] MAX_V  = LAT_W'(LAT_MAX);
  localparam logic [LAT_W-1:0] RST_V  = LAT_W'(LAT_RST);
  localparam logic [LAT_W-1:0] NOHF_V = LAT_W'(LAT_NOHF);

  logic legal;
  logic upd;

  // A write is taken only when the pair of fields is legal as a whole
  always_comb begin
    legal = (wr_lat >= MIN_V) && (wr_lat <= MAX_V) && !((wr_lat == NOHF_V) && wr_hf);
    upd   = wr_en && legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= RST_V;
      hf_q  <= 1'b0;
    end else if (upd) begin
      lat_q <= wr_lat;
      hf_q  <= wr_hf;
    end
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int AW     = 16,
  parameter int WRAP_W = 3,
  parameter int LAT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             stb_n,
  input  logic [AW-1:0]    addr_in,
  input  logic [LAT_W-1:0] lat,
  output logic             load,
  output logic             burst_on,
  output logic [WRAP_W-1:0] idx,
  output logic [AW-1:0]    word_addr
);

  seq_st_t              st_q, st_d;
  logic [LAT_W-1:0]     cnt_q, cnt_d;
  logic [AW-WRAP_W-1:0] base_q, base_d;
  logic [WRAP_W-1:0]    idx_q, idx_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    idx_d  = idx_q;
    load   = 1'b0;
    if (ce_n) begin
      st_d = ST_IDLE;
    end else if (!stb_n) begin
      // new start address: restart the latency count (also aborts a burst)
      st_d   = ST_WAIT;
      cnt_d  = LAT_W'(1);
      base_d = addr_in[AW-1:WRAP_W];
      idx_d  = addr_in[WRAP_W-1:0];
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (cnt_q == lat) begin
            load  = 1'b1;
            idx_d = idx_q + 1'b1;
            st_d  = ST_BURST;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_BURST: begin
          load  = 1'b1;
          idx_d = idx_q + 1'b1;  // wraps inside the aligned group
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
      idx_q  <= idx_d;
    end
  end

  assign burst_on  = (st_q == ST_BURST);
  assign idx       = idx_q;
  assign word_addr = {base_q, idx_q};

endmodule

// File: rtl/burst_word_src.sv
module burst_word_src #(
  parameter int              AW   = 16,
  parameter int              DW   = 16,
  parameter logic [DW-1:0]   SEED = 16'h5A3C
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);

  // Stand-in for the storage array: a fixed scramble of the word address
  assign word = DW'(addr) ^ SEED;

endmodule

// File: rtl/burst_rd_port.sv
module burst_rd_port #(
  parameter int            DW      = 16,
  parameter int            WRAP_W  = 3,
  parameter int            LAT_W   = 3,
  parameter int            LAT_MIN = 3,
  parameter int            LAT_MAX = 7,
  parameter int            LAT_RST = 4,
  parameter logic [DW-1:0] SEED    = 16'h5A3C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             addr_stb_n,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    ad_out,
  output logic             ad_drv,
  output logic             ready,
  input  logic             cfg_we,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             cfg_hf,
  output logic             hf_mode
);

  logic              rst_meta, rst_n_s;
  logic [LAT_W-1:0]  lat_q;
  logic              hf_q;
  logic              load;
  logic              burst_on;
  logic [WRAP_W-1:0] idx_q;
  logic [DW-1:0]     word_addr;
  logic [DW-1:0]     src_word;
  logic [DW-1:0]     dout_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  burst_lat_cfg #(
    .LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX), .LAT_RST(LAT_RST), .LAT_NOHF(LAT_MIN)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(cfg_we), .wr_lat(cfg_lat), .wr_hf(cfg_hf),
    .lat_q(lat_q), .hf_q(hf_q)
  );

  burst_seq #(.AW(DW), .WRAP_W(WRAP_W), .LAT_W(LAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .ce_n(ce_n), .stb_n(addr_stb_n), .addr_in(ad_in),
    .lat(lat_q), .load(load), .burst_on(burst_on), .idx(idx_q), .word_addr(word_addr)
  );

  burst_word_src #(.AW(DW), .DW(DW), .SEED(SEED)) u_src (
    .addr(word_addr), .word(src_word)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dout_q <= '0;
    end else if (load) begin
      dout_q <= src_word;
    end
  end

  assign ad_out  = dout_q;
  assign ad_drv  = burst_on && !ce_n && !oe_n;
  assign ready   = burst_on;
  assign hf_mode = hf_q;

endmodule

// File: rtl/burst_rd_chk.sv
module burst_rd_chk #(
  parameter int LAT_W   = 3,
  parameter int WRAP_W  = 3,
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              addr_stb_n,
  input logic              ad_drv,
  input logic              ready,
  input logic [LAT_W-1:0]  lat_q,
  input logic              hf_q,
  input logic [WRAP_W-1:0] idx_q
);

  p_drv_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !ad_drv);

  p_lat_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q >= LAT_W'(LAT_MIN)) && (lat_q <= LAT_W'(LAT_MAX)));

  p_lat_hf_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !((lat_q == LAT_W'(LAT_MIN)) && hf_q));

  p_strobe_drops_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !addr_stb_n) |=> !ready);

  p_ce_ends_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!ready && !ad_drv));

  p_word_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ce_n && addr_stb_n) |=> (ready && (idx_q == WRAP_W'($past(idx_q) + 1'b1))));

endmodule

bind burst_rd_port burst_rd_chk #(
  .LAT_W(LAT_W), .WRAP_W(WRAP_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .ce_n(ce_n), .oe_n(oe_n), .addr_stb_n(addr_stb_n),
  .ad_drv(ad_drv), .ready(ready), .lat_q(lat_q), .hf_q(hf_q), .idx_q(idx_q)
);

// File: tb/tb_burst_rd_port.sv
module tb_burst_rd_port;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SEED = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, addr_stb_n;
  logic [15:0] ad_in, ad_out;
  logic        ad_drv, ready;
  logic        cfg_we, cfg_hf;
  logic [2:0]  cfg_lat;
  logic        hf_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_rd_port dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr_stb_n(addr_stb_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_drv(ad_drv), .ready(ready),
    .cfg_we(cfg_we), .cfg_lat(cfg_lat), .cfg_hf(cfg_hf), .hf_mode(hf_mode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [15:0] base, input int j);
    return {base[15:3], 3'(int'(base[2:0]) + j)} ^ SEED;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_cfg(input logic [2:0] lat, input logic hf);
    cfg_we = 1'b1; cfg_lat = lat; cfg_hf = hf;
    tick();
    cfg_we = 1'b0;
  endtask

  // Starts (or restarts) a burst and checks latency and the first n words
  task automatic run_burst(input logic [15:0] base, input int lat, input int nwords, input string tag);
    ce_n = 1'b0; oe_n = 1'b0; addr_stb_n = 1'b0; ad_in = base;
    tick();                       // after latch edge E0
    addr_stb_n = 1'b1; ad_in = 16'h0;
    chk(!ready && !ad_drv, {tag, " R6/R11 ready low after latch"}, {ready, ad_drv}, 0);
    for (int k = 1; k < lat; k++) begin
      tick();
      chk(!ready && !ad_drv, {tag, " R6 ready low in wait"}, {ready, ad_drv}, 0);
    end
    tick();                       // after edge E0+L
    chk(ready && ad_drv && ad_out == exp_word(base, 0), {tag, " R5 first word"},
        {ready, ad_drv, ad_out}, {2'b11, exp_word(base, 0)});
    for (int j = 1; j < nwords; j++) begin
      tick();
      chk(ready && ad_out == exp_word(base, j), {tag, " R7/R8 next word"},
          {ready, ad_out}, {1'b1, exp_word(base, j)});
    end
  endtask

  task automatic end_burst(input string tag);
    ce_n = 1'b1; oe_n = 1'b1;
    tick();
    chk(!ready && !ad_drv, {tag, " R10 burst ends on ce_n"}, {ready, ad_drv}, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; addr_stb_n = 1'b1; ad_in = '0;
    cfg_we = 1'b0; cfg_lat = '0; cfg_hf = 1'b0;
    tick(); tick();
    chk(!ready && !ad_drv && !hf_mode, "R1 during reset", {ready, ad_drv, hf_mode}, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(!ready && !ad_drv && !hf_mode, "R1 after reset", {ready, ad_drv, hf_mode}, 0);
    run_burst(16'h0100, 4, 2, "R1 default latency");
    end_burst("R1");
  endtask

  task automatic t_lat_sweep();
    for (int l = 3; l <= 7; l++) begin
      do_cfg(3'(l), (l >= 6));
      chk(hf_mode == (l >= 6), "R2 hf bit accepted", hf_mode, (l >= 6));
      run_burst(16'h2000 + 16'(l * 8), l, 3, "R2 latency sweep");
      end_burst("R2");
    end
  endtask

  task automatic t_reject_range();
    do_cfg(3'd5, 1'b0);
    do_cfg(3'd2, 1'b1);
    do_cfg(3'd0, 1'b1);
    chk(!hf_mode, "R3 hf unchanged", hf_mode, 0);
    run_burst(16'h3A50, 5, 2, "R3 latency kept");
    end_burst("R3");
  endtask

  task automatic t_reject_pair();
    do_cfg(3'd6, 1'b1);
    do_cfg(3'd3, 1'b1);
    chk(hf_mode, "R4 hf unchanged", hf_mode, 1);
    run_burst(16'h4440, 6, 2, "R4 latency kept");
    end_burst("R4");
  endtask

  task automatic t_wrap();
    do_cfg(3'd3, 1'b0);
    run_burst(16'h1235, 3, 10, "R8 wrap in group");
    end_burst("R8");
  endtask

  task automatic t_oe_gate();
    ce_n = 1'b1; oe_n = 1'b0;
    #1;
    chk(!ad_drv, "R9 ce_n high disables drive", ad_drv, 0);
    run_burst(16'h5008, 3, 1, "R9 setup");
    oe_n = 1'b1;
    #1;
    chk(!ad_drv && ready, "R9 oe_n high disables drive", {ad_drv, ready}, 2'b01);
    tick();
    chk(!ad_drv && ad_out == exp_word(16'h5008, 1), "R9 burst runs with oe_n high",
        {ad_drv, ad_out}, {1'b0, exp_word(16'h5008, 1)});
    tick();
    oe_n = 1'b0;
    #1;
    chk(ad_drv && ad_out == exp_word(16'h5008, 2), "R9 drive back on",
        {ad_drv, ad_out}, {1'b1, exp_word(16'h5008, 2)});
    end_burst("R9");
  endtask

  task automatic t_restart();
    do_cfg(3'd4, 1'b0);
    run_burst(16'h6010, 4, 3, "R11 first burst");
    run_burst(16'h7FFE, 4, 3, "R11 restarted burst");
    end_burst("R11");
  endtask

  initial begin
    t_reset();
    t_lat_sweep();
    t_reject_range();
    t_reject_pair();
    t_wrap();
    t_oe_gate();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule